// File: doc/BRIEF.md
# Masked Set/Clear Control Register Bank

This block holds three 32-bit control registers: a command register, an interrupt-enable register and a mode register. Software changes them without a read-modify-write. Each register is split into four byte lanes, and each lane carries its own byte-enable strobe. In each written byte, the top bit is the value to store. The seven bits below it choose which register bits in that lane take the value. Register bits that are not chosen keep their contents.

Each register has a mask of implemented bits. Bits outside the mask, and the four value-bit positions, always hold 0. A plain read port returns any register combinationally. The full register contents also go to the surrounding logic as control outputs, and the four basic command controls have ports of their own. The poll-demand bits of the command register clear themselves one clock after they are set.

Top module: `cmdreg_bank`

## Requirements
- R1: Byte lane L covers register bits 8L+7 down to 8L, and `wr_strb[L]` enables it. Any combination of the four strobes may be used in one write.
- R2: In an enabled lane, data bit 8L+7 is the value. For each k from 0 to 6, data bit 8L+k selects register bit 8L+k. A selected bit takes the value and an unselected bit keeps its old contents.
- R3: Register bits outside the implemented mask, and bits 31, 23, 15 and 7, always read 0. The implemented masks are 0x000F0F7F for the command register (address 0), 0x1F7F7F1F for the interrupt-enable register (address 1) and 0x3F7F3F7F for the mode register (address 2).
- R4: A lane whose strobe is low keeps its contents, whatever the data bus carries for that lane.
- R5: Writing 0x9A to lane 0 alone sets bits 1, 3 and 4. Writing 0x1A to lane 0 alone clears those same bits.
- R6: Writing a register's own mask pattern with all four strobes high clears every implemented bit of that register.
- R7: Command register bit 0 drives `run`, bit 1 drives `int_enable`, bit 2 drives `tx_suspend` and bit 3 drives `rx_suspend`.
- R8: Command register bits 8 to 11 (transmit poll demand) and 16 to 19 (receive poll demand) stay 1 for exactly one clock after being written with value 1. They then return to 0 unless they are written again.
- R9: A synchronous active-high `rst` clears every register to 0.
- R10: A write to address 3 changes no register, and a read of address 3 returns 0.
- R11: `rd_data` shows the register at `rd_addr` in the same cycle. `cmd_q`, `irq_en_q` and `mode_q` always equal the contents of the matching register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register index for the write |
| wr_strb | input | 4 | Per-lane byte enables |
| wr_data | input | 32 | Value and select bits for each lane |
| rd_addr | input | 2 | Register index for the read |
| rd_data | output | 32 | Read data (combinational) |
| cmd_q | output | 32 | Command register contents |
| irq_en_q | output | 32 | Interrupt-enable register contents |
| mode_q | output | 32 | Mode register contents |
| run | output | 1 | Command bit 0 |
| int_enable | output | 1 | Command bit 1 |
| tx_suspend | output | 1 | Command bit 2 |
| rx_suspend | output | 1 | Command bit 3 |

## Verification
The bench builds the block with its default three registers and four 8-bit lanes, which keeps the input space small. For every register and every lane it sweeps all 256 byte values. It then sweeps all 16 strobe combinations with all-ones and all-clear data. A bit-by-bit model checks every result, so each select pattern, each value polarity and each unimplemented position is reached. Directed sequences add the self-clearing demand timing, the mask-pattern clear, writes to the unmapped address and reset.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int WORD_W   = 32;
    localparam int LANE_W   = 8;
    localparam int LANES    = WORD_W / LANE_W;
    localparam int NUM_REGS = 3;
    localparam int ADDR_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CMD   = 2'd0,
        REG_IRQEN = 2'd1,
        REG_MODE  = 2'd2
    } reg_sel_e;

    localparam logic [WORD_W-1:0] CMD_MASK     = 32'h000F_0F7F;
    localparam logic [WORD_W-1:0] IRQEN_MASK   = 32'h1F7F_7F1F;
    localparam logic [WORD_W-1:0] MODE_MASK    = 32'h3F7F_3F7F;
    localparam logic [WORD_W-1:0] CMD_SELFCLR  = 32'h000F_0F00;

    localparam int CMD_RUN_BIT  = 0;
    localparam int CMD_IEN_BIT  = 1;
    localparam int CMD_TXSP_BIT = 2;
    localparam int CMD_RXSP_BIT = 3;

    typedef struct packed {
        logic run;
        logic int_en;
        logic tx_susp;
        logic rx_susp;
    } cmd_ctl_t;

    function automatic logic [WORD_W-1:0] value_positions();
        logic [WORD_W-1:0] v;
        v = '0;
        for (int l = 0; l < LANES; l++) v[l*LANE_W + LANE_W - 1] = 1'b1;
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] reg_mask(int idx);
        case (idx)
            0:       return CMD_MASK;
            1:       return IRQEN_MASK;
            2:       return MODE_MASK;
            default: return '0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] reg_selfclr(int idx);
        return (idx == 0) ? CMD_SELFCLR : '0;
    endfunction

    function automatic cmd_ctl_t decode_cmd(logic [WORD_W-1:0] q);
        cmd_ctl_t c;
        c.run     = q[CMD_RUN_BIT];
        c.int_en  = q[CMD_IEN_BIT];
        c.tx_susp = q[CMD_TXSP_BIT];
        c.rx_susp = q[CMD_RXSP_BIT];
        return c;
    endfunction

endpackage

// File: rtl/cmdreg_lane_merge.sv
module cmdreg_lane_merge #(
    parameter int               LANE_W = 8,
    parameter logic [LANE_W-1:0] IMPL  = '1
) (
    input  logic              en,
    input  logic [LANE_W-1:0] old_bits,
    input  logic [LANE_W-1:0] wr_byte,
    output logic [LANE_W-1:0] new_bits
);
    localparam int SEL_W = LANE_W - 1;

    logic             val;
    logic [SEL_W-1:0] sel;
    logic [SEL_W-1:0] merged;

    always_comb begin
        val    = wr_byte[LANE_W-1];
        sel    = wr_byte[SEL_W-1:0];
        merged = en ? ((old_bits[SEL_W-1:0] & ~sel) | ({SEL_W{val}} & sel))
                    : old_bits[SEL_W-1:0];
        // value-bit position never stores; unimplemented bits forced low
        new_bits = {1'b0, merged} & IMPL;
    end
endmodule

// File: rtl/cmdreg_slice.sv
module cmdreg_slice #(
    parameter int                WORD_W  = cmdreg_pkg::WORD_W,
    parameter int                LANE_W  = cmdreg_pkg::LANE_W,
    parameter logic [WORD_W-1:0] MASK    = '0,
    parameter logic [WORD_W-1:0] SELFCLR = '0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_hit,
    input  logic [WORD_W/LANE_W-1:0]   wr_strb,
    input  logic [WORD_W-1:0]          wr_data,
    output logic [WORD_W-1:0]          q
);
    localparam int LANES = WORD_W / LANE_W;
    localparam logic [WORD_W-1:0] VALPOS = cmdreg_pkg::value_positions();
    localparam logic [WORD_W-1:0] IMPL   = MASK & ~VALPOS;

    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] nxt;

    // demand bits decay before any new write is merged in
    assign base = q & ~SELFCLR;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cmdreg_lane_merge #(
            .LANE_W (LANE_W),
            .IMPL   (IMPL[l*LANE_W +: LANE_W])
        ) u_merge (
            .en       (wr_hit && wr_strb[l]),
            .old_bits (base[l*LANE_W +: LANE_W]),
            .wr_byte  (wr_data[l*LANE_W +: LANE_W]),
            .new_bits (nxt[l*LANE_W +: LANE_W])
        );

        assert_strobe_low_keeps_R4: assert property (@(posedge clk) disable iff (rst)
            (wr_hit && !wr_strb[l]) |=>
            ((q[l*LANE_W +: LANE_W] & ~SELFCLR[l*LANE_W +: LANE_W]) ==
             $past(q[l*LANE_W +: LANE_W] & ~SELFCLR[l*LANE_W +: LANE_W])));

        assert_select_takes_value_R2: assert property (@(posedge clk) disable iff (rst)
            (wr_hit && wr_strb[l]) |=>
            (((q[l*LANE_W +: LANE_W-1] ^ {(LANE_W-1){$past(wr_data[l*LANE_W+LANE_W-1])}})
              & $past(wr_data[l*LANE_W +: LANE_W-1])
              & IMPL[l*LANE_W +: LANE_W-1]) == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (q & ~IMPL) == '0);

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> ((q & ~SELFCLR) == $past(q & ~SELFCLR)));

    assert_demand_decays_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> ((q & SELFCLR) == '0));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (q == '0));
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank
    import cmdreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [3:0]  wr_strb,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic [31:0] cmd_q,
    output logic [31:0] irq_en_q,
    output logic [31:0] mode_q,
    output logic        run,
    output logic        int_enable,
    output logic        tx_suspend,
    output logic        rx_suspend
);
    logic [WORD_W-1:0] regs_q [NUM_REGS];
    logic [NUM_REGS-1:0] wr_hit;
    cmd_ctl_t ctl;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        assign wr_hit[g] = wr_en && (wr_addr == ADDR_W'(g));

        cmdreg_slice #(
            .WORD_W  (WORD_W),
            .LANE_W  (LANE_W),
            .MASK    (reg_mask(g)),
            .SELFCLR (reg_selfclr(g))
        ) u_slice (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (wr_hit[g]),
            .wr_strb (wr_strb),
            .wr_data (wr_data),
            .q       (regs_q[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
    end

    assign cmd_q    = regs_q[REG_CMD];
    assign irq_en_q = regs_q[REG_IRQEN];
    assign mode_q   = regs_q[REG_MODE];

    assign ctl        = decode_cmd(cmd_q);
    assign run        = ctl.run;
    assign int_enable = ctl.int_en;
    assign tx_suspend = ctl.tx_susp;
    assign rx_suspend = ctl.rx_susp;

    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd3) |=>
        ((irq_en_q == $past(irq_en_q)) && (mode_q == $past(mode_q))));
endmodule

// File: tb/cmdreg_bank_tb_top.sv
`timescale 1ns/1ps
module cmdreg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data, cmd_q, irq_en_q, mode_q;
    logic        run, int_enable, tx_suspend, rx_suspend;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] model [3];
    localparam logic [31:0] M_CMD = 32'h000F0F7F;
    localparam logic [31:0] M_IEN = 32'h1F7F7F1F;
    localparam logic [31:0] M_MOD = 32'h3F7F3F7F;
    localparam logic [31:0] SC    = 32'h000F0F00;

    always #5 clk = ~clk;

    cmdreg_bank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_strb(wr_strb), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cmd_q(cmd_q), .irq_en_q(irq_en_q), .mode_q(mode_q),
        .run(run), .int_enable(int_enable), .tx_suspend(tx_suspend),
        .rx_suspend(rx_suspend)
    );

    function automatic logic [31:0] mask_of(int r);
        return (r == 0) ? M_CMD : (r == 1) ? M_IEN : (r == 2) ? M_MOD : 32'h0;
    endfunction

    function automatic logic [31:0] apply(logic [31:0] old, logic [3:0] s,
                                          logic [31:0] d, logic [31:0] m);
        logic [31:0] n;
        for (int b = 0; b < 32; b++) begin
            int ln = b / 8;
            int p  = b % 8;
            if (p == 7)                     n[b] = 1'b0;
            else if (s[ln] && d[ln*8 + p])  n[b] = d[ln*8 + 7];
            else                            n[b] = old[b];
        end
        return n & m;
    endfunction

    function automatic logic [31:0] port_of(int r);
        return (r == 0) ? cmd_q : (r == 1) ? irq_en_q : mode_q;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // write at one edge, check after it, then let demand bits decay one edge
    task automatic do_write(string tag, int r, logic [3:0] s, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(r); wr_strb = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = ~d;
        if (r < 3) model[r] = apply(model[r], s, d, mask_of(r));
        rd_addr = 2'(r);
        #1;
        if (r < 3) begin
            chk(tag, rd_data, model[r]);
            chk({tag, "/R11 port"}, port_of(r), model[r]);
        end
        @(negedge clk);
        model[0] = model[0] & ~SC;
    endtask

    initial begin
        for (int i = 0; i < 3; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset state
        chk("R9 cmd", cmd_q, 32'h0);
        chk("R9 irq", irq_en_q, 32'h0);
        chk("R9 mode", mode_q, 32'h0);

        // R5: worked example on lane 0
        do_write("R5 set", 0, 4'b0001, 32'h0000_009A);
        chk("R5 set bits", cmd_q, 32'h0000_001A);
        do_write("R5 clr", 0, 4'b0001, 32'h0000_001A);
        chk("R5 clr bits", cmd_q, 32'h0);

        // R7: command controls
        do_write("R7 set", 0, 4'b0001, 32'h0000_008F);
        chk("R7 ctl", {28'h0, rx_suspend, tx_suspend, int_enable, run}, 32'hF);
        do_write("R7 clr run", 0, 4'b0001, 32'h0000_0001);
        chk("R7 ctl2", {28'h0, rx_suspend, tx_suspend, int_enable, run}, 32'hE);

        // R8: demand bits live for one clock
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_strb = 4'b0110; wr_data = 32'h008F_8F00;
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R8 demand set", cmd_q & SC, SC);
        @(negedge clk);
        #1 chk("R8 demand cleared", cmd_q & SC, 32'h0);
        chk("R8 others kept", cmd_q, model[0]);

        // R2/R3: every byte value into every lane of every register
        for (int r = 0; r < 3; r++)
            for (int l = 0; l < 4; l++)
                for (int v = 0; v < 256; v++)
                    do_write("R2/R3 sweep", r, 4'(1 << l), 32'(v) << (8 * l));

        // R1/R4: every strobe combination
        for (int r = 0; r < 3; r++)
            for (int s = 0; s < 16; s++) begin
                do_write("R1 set", r, 4'(s), 32'hFFFF_FFFF);
                do_write("R4 clr", r, 4'(15 - s), 32'h7F7F_7F7F);
            end

        // R6: mask pattern clears everything
        for (int r = 0; r < 3; r++) begin
            do_write("R6 fill", r, 4'hF, 32'hFFFF_FFFF);
            do_write("R6 clear", r, 4'hF, mask_of(r));
            chk("R6 zero", port_of(r), 32'h0);
        end

        // R10: unmapped address
        do_write("R10 fill", 1, 4'hF, 32'hFFFF_FFFF);
        do_write("R10 fill", 2, 4'hF, 32'hFFFF_FFFF);
        do_write("R10 write", 3, 4'hF, 32'h7F7F_7F7F);
        chk("R10 irq kept", irq_en_q, M_IEN);
        chk("R10 mode kept", mode_q, M_MOD);
        rd_addr = 2'd3;
        #1 chk("R10 read zero", rd_data, 32'h0);

        // R9: reset after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R9 re-reset irq", irq_en_q, 32'h0);
        chk("R9 re-reset mode", mode_q, 32'h0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule